// File: doc/BRIEF.md
# Four-bit accumulator CPU core

This is a very small processor with four-bit data. It holds two working registers (A and B), an output latch, a program counter and a carry flag. On every clock edge it runs one eight-bit instruction that it fetches from a sixteen-word program store outside the core. The core drives the fetch address. The store returns the instruction word in the same cycle, with no latency.

All instructions use one shared datapath. A four-way selector picks one operand: A, B, the input port or the constant zero. An adder adds the instruction's immediate field to that operand. The sum is written to exactly one destination, which is A, B, the output latch or the program counter. A move is therefore an addition with a zero operand, an output is an addition into the latch, and a jump is zero plus the immediate loaded into the program counter. Every instruction adds its immediate, including moves and outputs. The conditional jump looks at the carry left by the previous instruction and is taken only when that carry is clear.

Top module: `cpu4_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a clock edge, A, B, the output latch, the program counter and the carry are cleared, so `out_port` and `iaddr` read 0 after that edge.
- R2: `iaddr` is the program counter. Bits 7:4 of `instr` are the opcode and bits 3:0 are the immediate. When the counter is not loaded it advances by one per clock and wraps from 15 to 0.
- R3: The operand code is {opcode bit 1, opcode bit 0 OR opcode bit 3}. Code 0 selects A, 1 selects B, 2 selects `in_port` and 3 selects zero. Examples: 0001 and 1001 select B, 0010 and 0110 select the input, and 1011, 1110 and 1111 select zero.
- R4: Opcode bits 3:2 pick the destination: 00 is A, 01 is B, 10 is the output latch and 11 is the program counter.
- R5: The value written is (operand + immediate) mod 16 for every instruction. For example, opcode 1001 with immediate 1 outputs B+1, and opcode 0100 with immediate 2 writes A+2 into B.
- R6: The carry flag takes the adder's carry-out on every executed instruction, whatever its opcode, including outputs and moves.
- R7: Opcode 1110 loads the program counter with the immediate only when the stored carry is 0. Otherwise the counter advances by one.
- R8: Opcode 1111 always loads the program counter with the immediate, whatever the carry.
- R9: A register that is not the destination of an instruction keeps its value.
- R10: Adding immediate 15 to a nonzero operand decrements it by one and sets the carry. Adding 15 to zero gives 15 with the carry clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 4 | Input port value, one of the operand choices |
| instr | input | 8 | Instruction word returned by the program store for `iaddr` |
| iaddr | output | 4 | Program counter, used as the fetch address |
| out_port | output | 4 | Registered output latch |

## Verification
The hardest case to reach from the ports is a conditional jump whose outcome depends on a carry produced by an instruction that does not look arithmetic, such as an output that overflows or a decrement by adding 15. That carry is never visible directly. The programs are therefore built so that a conditional jump directly follows each such instruction, and the carry is inferred from the next fetch address. The working registers are hidden as well, so the stimulus copies them out through output instructions. A behavioural model predicts the address and the latch on every cycle.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_IN   = 2'd2,
    SRC_ZERO = 2'd3
  } src_t;

  typedef struct packed {
    src_t src;
    logic wr_a;
    logic wr_b;
    logic wr_out;
    logic wr_pc;
  } ctrl_t;
endpackage

// File: rtl/cpu4_decode.sv
module cpu4_decode
  import cpu4_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             carry,
  output ctrl_t            ctrl
);
  logic [1:0] dest;

  always_comb begin
    dest        = opc[3:2];
    ctrl.src    = src_t'({opc[1], opc[0] | opc[3]});
    ctrl.wr_a   = (dest == 2'b00);
    ctrl.wr_b   = (dest == 2'b01);
    ctrl.wr_out = (dest == 2'b10);
    ctrl.wr_pc  = (dest == 2'b11) && (opc[0] || !carry);
  end
endmodule

// File: rtl/cpu4_datapath.sv
module cpu4_datapath
  import cpu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] inp,
  input  src_t         src,
  input  logic [W-1:0] imm,
  output logic [W-1:0] opnd,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;

  always_comb begin
    unique case (src)
      SRC_A:   opnd = a;
      SRC_B:   opnd = b;
      SRC_IN:  opnd = inp;
      default: opnd = '0;
    endcase
  end

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = opnd[i] ^ imm[i] ^ cy[i];
    assign cy[i+1] = (opnd[i] & imm[i]) | (cy[i] & (opnd[i] ^ imm[i]));
  end

  assign cout = cy[W];
endmodule

// File: rtl/cpu4_ldreg.sv
module cpu4_ldreg #(
  parameter int W    = 4,
  parameter bit STEP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  if (STEP) begin : g_count
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
      else         q <= q + ONE;
    end
  end else begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
    end
  end
endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         in_port,
  input  logic [W+OPC_W-1:0]   instr,
  output logic [W-1:0]         iaddr,
  output logic [W-1:0]         out_port
);
  localparam int IW = W + OPC_W;

  logic [OPC_W-1:0] opc;
  logic [W-1:0]     imm;
  logic [W-1:0]     a_q, b_q, opnd, sum;
  logic             cout, carry_q;
  ctrl_t            ctrl;

  assign opc = instr[IW-1 -: OPC_W];
  assign imm = instr[W-1:0];

  cpu4_decode u_dec (
    .opc   (opc),
    .carry (carry_q),
    .ctrl  (ctrl)
  );

  cpu4_datapath #(.W(W)) u_dp (
    .a    (a_q),
    .b    (b_q),
    .inp  (in_port),
    .src  (ctrl.src),
    .imm  (imm),
    .opnd (opnd),
    .sum  (sum),
    .cout (cout)
  );

  cpu4_ldreg #(.W(W), .STEP(1'b0)) u_reg_a (
    .clk(clk), .rst(rst), .ld(ctrl.wr_a), .d(sum), .q(a_q)
  );

  cpu4_ldreg #(.W(W), .STEP(1'b0)) u_reg_b (
    .clk(clk), .rst(rst), .ld(ctrl.wr_b), .d(sum), .q(b_q)
  );

  cpu4_ldreg #(.W(W), .STEP(1'b0)) u_reg_out (
    .clk(clk), .rst(rst), .ld(ctrl.wr_out), .d(sum), .q(out_port)
  );

  cpu4_ldreg #(.W(W), .STEP(1'b1)) u_reg_pc (
    .clk(clk), .rst(rst), .ld(ctrl.wr_pc), .d(sum), .q(iaddr)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= cout;
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.wr_pc |=> iaddr == W'($past(iaddr) + 1'b1));

  // R5
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    {cout, sum} == ({1'b0, opnd} + {1'b0, imm}));

  // R7
  cond_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b1110 && carry_q) |=> iaddr == W'($past(iaddr) + 1'b1));

  // R8
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b1111) |=> iaddr == $past(imm));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opc[3:2] != 2'b10) |=> $stable(out_port));

  // R10
  dec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b0000 && imm == '1 && a_q != '0) |=> carry_q);
endmodule

// File: tb/cpu4_core_test.sv
`timescale 1ns/1ps
module cpu4_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] in_port = 4'd0;
  logic [7:0] instr;
  logic [3:0] iaddr, out_port;
  logic [7:0] prog [16];

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int ma, mb, mo, mpc, mc;
  int hist_out [32];
  int hist_pc  [32];

  always #2.5 clk = ~clk;

  assign instr = prog[iaddr];

  cpu4_core uut (
    .clk(clk), .rst(rst), .in_port(in_port), .instr(instr),
    .iaddr(iaddr), .out_port(out_port)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int op, im, opv, s;
    op = prog[mpc][7:4];
    im = prog[mpc][3:0];
    case (op)
      0, 4:                opv = ma;
      1, 5, 9:             opv = mb;
      2, 6:                opv = in_port;
      default:             opv = 0;
    endcase
    s = opv + im;
    mpc = (mpc + 1) % 16;
    case (op)
      0, 1, 2, 3: ma = s % 16;
      4, 5, 6, 7: mb = s % 16;
      9, 11:      mo = s % 16;
      14:         if (mc == 0) mpc = s % 16;
      15:         mpc = s % 16;
      default:    ;
    endcase
    mc = (s > 15) ? 1 : 0;
  endtask

  task automatic run(input int n, input string tag);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset out_port", out_port, 0);
    check("R1 reset iaddr", iaddr, 0);
    ma = 0; mb = 0; mo = 0; mpc = 0; mc = 0;
    rst = 1'b0;
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      check({tag, " R2 iaddr"}, iaddr, mpc);
      check({tag, " R5 out_port"}, out_port, mo);
      hist_out[i] = out_port;
      hist_pc[i]  = iaddr;
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int k = 0; k < 16; k++) prog[k] = v;
  endtask

  initial begin
    fill(8'h00);
    repeat (2) @(negedge clk);

    // Program 1: plain sequencing, counter wrap (R2)
    run(17, "seq");
    check("R2 pc reaches 15", hist_pc[14], 15);
    check("R2 pc wraps to 0", hist_pc[15], 0);

    // Program 2: operand selection, destinations, immediates (R3 R4 R5 R9)
    rst = 1'b1;
    fill(8'h00);
    in_port = 4'd6;
    prog[0] = 8'h33; prog[1] = 8'h04; prog[2] = 8'h42; prog[3] = 8'h91;
    prog[4] = 8'h21; prog[5] = 8'h3C; prog[6] = 8'h90; prog[7] = 8'h40;
    prog[8] = 8'h61; prog[9] = 8'h90; prog[10] = 8'h14; prog[11] = 8'h40;
    prog[12] = 8'h90; prog[13] = 8'hBE; prog[14] = 8'hF0;
    run(20, "ops R3 R4");
    check("R5 out B+1", hist_out[3], 10);
    check("R9 B kept over A writes", hist_out[6], 9);
    check("R3 input operand", hist_out[9], 7);
    check("R3 B operand to A", hist_out[12], 11);
    check("R4 out immediate", hist_out[13], 14);

    // Program 3: carry and conditional jump (R6 R7 R10)
    rst = 1'b1;
    fill(8'hB1);
    in_port = 4'd0;
    prog[0] = 8'h3F; prog[1] = 8'h01; prog[2] = 8'hE6; prog[3] = 8'hE8;
    prog[8] = 8'hB9; prog[9] = 8'h0F; prog[10] = 8'h0F; prog[11] = 8'hED;
    prog[12] = 8'hB3; prog[13] = 8'h40; prog[14] = 8'h92; prog[15] = 8'hE5;
    run(20, "carry R6");
    check("R7 not taken with carry", hist_pc[2], 3);
    check("R7 taken without carry", hist_pc[3], 8);
    check("R10 15 plus 15 gives carry", hist_pc[7], 12);
    check("R6 carry from output add", hist_out[10], 0);
    check("R6 jump skipped after output carry", hist_pc[11], 0);

    // Program 4: unconditional jump with carry set (R8)
    rst = 1'b1;
    fill(8'h00);
    prog[0] = 8'h3F; prog[1] = 8'h0F; prog[2] = 8'hF9;
    prog[9] = 8'hB4; prog[10] = 8'hFA;
    run(8, "jump R8");
    check("R8 jump despite carry", hist_pc[2], 9);
    check("R8 target executed", hist_out[3], 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule